// File: doc/BRIEF.md
# Memory-Reference Instruction Execution Unit

This unit carries out the memory-reference class of instructions for a small 16-bit accumulator machine, one instruction per start request. It keeps the accumulator, the one-bit link and the program counter. It talks to a word-addressed memory through a single synchronous port that performs one read or one write per clock, with read data arriving one clock after the address.

A pulse on `start` makes the unit read the word at the program counter and decode its opcode field and its indirect flag. When the flag is set, the unit fetches a pointer word to obtain the effective address. It then performs a jump, a store, an exchange, an add or an increment-and-skip. When the instruction completes, it raises `done` for one clock together with the number of machine cycles the instruction is defined to take. Any other opcode is treated as a one-cycle no-op. While the unit is idle, a preset port lets the surrounding machine load the three registers.

Top module: `mri_exec`

## Requirements
- R1: After a synchronous active-low reset, the accumulator, link and program counter are zero and `done` is low.
- R2: While the unit is idle and `start` is low, `set_en` loads `set_ac`, `set_link` and `set_pc` into the registers at the next clock.
- R3: An instruction word is decoded as follows. Bit 15 is the indirect flag and bits 10..0 are the address field. Bits 14..11 hold the opcode: 2 selects jump, 4 selects store, 5 selects exchange, 6 selects increment-and-skip and 13 selects add. With bit 15 clear, the effective address is the address field.
- R4: With bit 15 set, the low 11 bits of the word stored at the address field become the effective address.
- R5: When `done` is high, `cycles` reads 2 for a direct instruction, 3 for an indirect instruction and 1 for a no-op.
- R6: `done` is a single-clock pulse. Count the clock edge that samples `start` as edge 0. `done` then appears after edge 1 for a no-op, after edge 2 for a direct jump or store, and after edge 3 for a direct exchange, add or increment. An indirect instruction takes one more edge.
- R7: A jump loads the program counter with the effective address and leaves the accumulator and link unchanged.
- R8: A store writes the accumulator to the effective address, leaves the accumulator and link unchanged and advances the program counter by one.
- R9: An exchange swaps the accumulator with the memory word at the effective address, leaves the link unchanged and advances the program counter by one.
- R10: An add places the 16-bit sum of the accumulator and the memory word in the accumulator. A carry out of bit 15 inverts the link, and without a carry the link is kept. The program counter advances by one.
- R11: An increment-and-skip writes the memory word plus one back to memory and leaves the accumulator and link unchanged. The program counter advances by two when the result is zero, and by one otherwise.
- R12: An opcode outside the five listed is a no-op: the program counter advances by one, memory is not written and the accumulator and link are unchanged, whatever the value of bit 15.
- R13: The program counter changes only at `done` or by preset. The accumulator changes only at `done` of an exchange or an add, or by preset. The program counter wraps modulo 2^11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one instruction at the current program counter |
| set_en | input | 1 | Preset strobe, honoured when idle |
| set_ac | input | 16 | Preset accumulator value |
| set_link | input | 1 | Preset link value |
| set_pc | input | 11 | Preset program counter value |
| mem_addr | output | 11 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, one clock after the address |
| done | output | 1 | Instruction complete pulse |
| cycles | output | 2 | Machine cycles used, valid with done |
| acc | output | 16 | Accumulator |
| link | output | 1 | Link bit |
| pc | output | 11 | Program counter |

## Verification
On every clock, the assertions check that `done` lasts a single clock, that the reported cycle count is in range, that the link moves only when an add completes, and that the accumulator and program counter move only at completion or preset. They also check that memory writes happen only in the operand phases. The bench scenarios are needed to show the actual arithmetic: the link inverting on carry, the skip on an increment that wraps, and the pointer following for indirect instructions. The same holds for the exact clock on which `done` arrives and for the values written into memory.

// File: rtl/mri_pkg.sv
// Shared types for the memory-reference execution unit.
// Assumes a 16-bit word with the opcode in the four bits below the indirect flag.
package mri_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;

    localparam logic [OPC_W-1:0] OPC_JMP = 4'd2;
    localparam logic [OPC_W-1:0] OPC_DAC = 4'd4;
    localparam logic [OPC_W-1:0] OPC_XAM = 4'd5;
    localparam logic [OPC_W-1:0] OPC_ISZ = 4'd6;
    localparam logic [OPC_W-1:0] OPC_ADD = 4'd13;

    typedef enum logic [2:0] {
        K_NOP, K_JMP, K_DAC, K_XAM, K_ISZ, K_ADD
    } kind_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_INDIR, ST_OPER, ST_FIN
    } state_t;

endpackage

// File: rtl/mri_decode.sv
// Instruction word decoder: splits a word into kind, indirect flag and address field.
// Assumes the address field fits below the opcode field (ADDR_W <= WORD_W - 5).
module mri_decode
    import mri_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [WORD_W-1:0] word,
    output kind_t             kind,
    output logic              ind,
    output logic [ADDR_W-1:0] field
);
    localparam int OPC_HI = WORD_W - 2;

    logic [OPC_W-1:0] opc;

    // Extract the fixed-position fields.
    always_comb begin
        ind   = word[WORD_W-1];
        opc   = word[OPC_HI -: OPC_W];
        field = word[ADDR_W-1:0];
    end

    // Map the opcode to an instruction kind; unknown codes become a no-op.
    always_comb begin
        case (opc)
            OPC_JMP: kind = K_JMP;
            OPC_DAC: kind = K_DAC;
            OPC_XAM: kind = K_XAM;
            OPC_ISZ: kind = K_ISZ;
            OPC_ADD: kind = K_ADD;
            default: kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/mri_alu.sv
// Arithmetic for add and increment-and-skip.
// Add inverts the link on carry out; increment reports a wrap to zero.
module mri_alu
    import mri_pkg::*;
(
    input  logic [WORD_W-1:0] ac,
    input  logic [WORD_W-1:0] opnd,
    input  logic              link_in,
    output logic [WORD_W-1:0] sum,
    output logic              link_out,
    output logic [WORD_W-1:0] inc,
    output logic              inc_zero
);
    logic [WORD_W:0] wide;

    // Sum with carry; the carry toggles the link rather than loading it.
    always_comb begin
        wide     = {1'b0, ac} + {1'b0, opnd};
        sum      = wide[WORD_W-1:0];
        link_out = link_in ^ wide[WORD_W];
    end

    // Increment and zero detection for the skip decision.
    always_comb begin
        inc      = opnd + 1'b1;
        inc_zero = (inc == '0);
    end
endmodule

// File: rtl/mri_ctrl.sv
// Phase sequencer: idle, fetch, pointer read, operand phase, finish.
// Assumes the decode of the fetched word is valid during the fetch phase.
module mri_ctrl
    import mri_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  kind_t  dec_kind,
    input  logic   dec_ind,
    input  kind_t  held_kind,
    output state_t st,
    output logic   finish
);
    state_t nxt;

    // Next-phase selection and completion detect.
    always_comb begin
        nxt    = st;
        finish = 1'b0;
        case (st)
            ST_IDLE:  if (start) nxt = ST_FETCH;
            ST_FETCH: begin
                if (dec_kind == K_NOP) begin
                    nxt    = ST_IDLE;
                    finish = 1'b1;
                end else if (dec_ind) begin
                    nxt = ST_INDIR;
                end else begin
                    nxt = ST_OPER;
                end
            end
            ST_INDIR: nxt = ST_OPER;
            ST_OPER: begin
                if (held_kind == K_JMP || held_kind == K_DAC) begin
                    nxt    = ST_IDLE;
                    finish = 1'b1;
                end else begin
                    nxt = ST_FIN;
                end
            end
            ST_FIN: begin
                nxt    = ST_IDLE;
                finish = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end
endmodule

// File: rtl/mri_exec.sv
// Memory-reference instruction execution unit: holds AC, link and PC,
// drives a one-access-per-clock memory port with one-clock read latency.
// Assumes memory returns mem_rdata for the address presented on the prior clock.
module mri_exec
    import mri_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              set_en,
    input  logic [WORD_W-1:0] set_ac,
    input  logic              set_link,
    input  logic [ADDR_W-1:0] set_pc,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [1:0]        cycles,
    output logic [WORD_W-1:0] acc,
    output logic              link,
    output logic [ADDR_W-1:0] pc
);
    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PC_TWO = ADDR_W'(2);

    state_t            st;
    logic              finish;
    kind_t             dec_kind;
    logic              dec_ind;
    logic [ADDR_W-1:0] dec_field;
    kind_t             ir_kind;
    logic [ADDR_W-1:0] ea;
    logic [WORD_W-1:0] sum, inc;
    logic              link_nx, inc_zero;
    logic              preload;

    mri_decode #(.ADDR_W(ADDR_W)) u_dec (
        .word (mem_rdata),
        .kind (dec_kind),
        .ind  (dec_ind),
        .field(dec_field)
    );

    mri_alu u_alu (
        .ac      (acc),
        .opnd    (mem_rdata),
        .link_in (link),
        .sum     (sum),
        .link_out(link_nx),
        .inc     (inc),
        .inc_zero(inc_zero)
    );

    mri_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dec_kind (dec_kind),
        .dec_ind  (dec_ind),
        .held_kind(ir_kind),
        .st       (st),
        .finish   (finish)
    );

    assign preload = (st == ST_IDLE) && set_en && !start;

    // Memory port steering per phase.
    always_comb begin
        mem_addr  = ea;
        mem_wdata = acc;
        mem_we    = 1'b0;
        case (st)
            ST_IDLE:  mem_addr = pc;
            ST_FETCH: mem_addr = dec_field;
            ST_OPER:  mem_we   = (ir_kind == K_DAC);
            ST_FIN: begin
                mem_we    = (ir_kind == K_XAM) || (ir_kind == K_ISZ);
                mem_wdata = (ir_kind == K_ISZ) ? inc : acc;
            end
            default: ;
        endcase
    end

    // Latch decode results and the effective address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_kind <= K_NOP;
            ea      <= '0;
            cycles  <= 2'd0;
        end else if (st == ST_FETCH) begin
            ir_kind <= dec_kind;
            ea      <= dec_field;
            cycles  <= (dec_kind == K_NOP) ? 2'd1 : (dec_ind ? 2'd3 : 2'd2);
        end else if (st == ST_INDIR) begin
            ea <= mem_rdata[ADDR_W-1:0];
        end
    end

    // Architectural register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            link <= 1'b0;
            pc   <= '0;
        end else if (preload) begin
            acc  <= set_ac;
            link <= set_link;
            pc   <= set_pc;
        end else begin
            case (st)
                ST_FETCH: if (dec_kind == K_NOP) pc <= pc + PC_ONE;
                ST_OPER: begin
                    if (ir_kind == K_JMP)      pc <= ea;
                    else if (ir_kind == K_DAC) pc <= pc + PC_ONE;
                end
                ST_FIN: begin
                    case (ir_kind)
                        K_XAM: begin
                            acc <= mem_rdata;
                            pc  <= pc + PC_ONE;
                        end
                        K_ADD: begin
                            acc  <= sum;
                            link <= link_nx;
                            pc   <= pc + PC_ONE;
                        end
                        K_ISZ: pc <= pc + (inc_zero ? PC_TWO : PC_ONE);
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= finish;
    end

    // Marks that a previous cycle exists for $past comparisons.
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_cycles_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles != 2'd0));

    p_link_add_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(preload) && link != $past(link)) |-> (done && ir_kind == K_ADD));

    p_ac_guard_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(preload) && acc != $past(acc))
            |-> (done && (ir_kind == K_XAM || ir_kind == K_ADD)));

    p_pc_guard_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(preload) && pc != $past(pc)) |-> done);

    p_write_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (st == ST_OPER || st == ST_FIN));
endmodule

// File: tb/mri_exec_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the unit on every clock.
module mri_exec_test;
    localparam int AW = 11;
    localparam int DEPTH = 1 << AW;
    localparam int AMASK = DEPTH - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        set_en = 1'b0;
    logic [15:0] set_ac = '0;
    logic        set_link = 1'b0;
    logic [AW-1:0] set_pc = '0;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic        done;
    logic [1:0]  cycles;
    logic [15:0] acc;
    logic        link;
    logic [AW-1:0] pc;

    always #2.5 clk = ~clk;

    mri_exec #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .set_en(set_en),
        .set_ac(set_ac), .set_link(set_link), .set_pc(set_pc),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .done(done), .cycles(cycles),
        .acc(acc), .link(link), .pc(pc)
    );

    // Synchronous memory model, one-clock read latency.
    logic [15:0] mem [0:DEPTH-1];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0o expected %0o", req, what, act, exp);
        end
    endtask

    task automatic poke(input int a, input int v);
        mem[a] <= v[15:0];
    endtask

    // Preset registers, then run one instruction and compare every clock.
    task automatic run(input string req, input int pc0, input int ac0, input int l0);
        int w, ind, opc, fld, ea, m, s, v;
        int e_ac, e_l, e_pc, e_cyc, lat, wr, wv;
        @(negedge clk);
        set_en = 1'b1; set_ac = ac0[15:0]; set_link = l0[0]; set_pc = pc0[AW-1:0];
        @(negedge clk);
        set_en = 1'b0;
        chk("R2", "preset pc", int'(pc), pc0);
        chk("R2", "preset acc", int'(acc), ac0);
        // reference model
        w = int'(mem[pc0]); ind = (w >> 15) & 1; opc = (w >> 11) & 15; fld = w & AMASK;
        ea = ind ? (int'(mem[fld]) & AMASK) : fld;
        m = int'(mem[ea]);
        e_ac = ac0; e_l = l0; e_pc = (pc0 + 1) & AMASK; wr = 0; wv = 0;
        e_cyc = ind ? 3 : 2;
        lat = 2 + ind;
        case (opc)
            2: e_pc = ea;
            4: begin wr = 1; wv = ac0; end
            5: begin wr = 1; wv = ac0; e_ac = m; lat++; end
            13: begin
                s = ac0 + m; e_ac = s & 16'hffff;
                if (s > 16'hffff) e_l = l0 ^ 1;
                lat++;
            end
            6: begin
                v = (m + 1) & 16'hffff; wr = 1; wv = v;
                if (v == 0) e_pc = (pc0 + 2) & AMASK;
                lat++;
            end
            default: begin e_cyc = 1; lat = 1; end
        endcase
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= lat + 1; k++) begin
            @(negedge clk);
            chk("R6", $sformatf("%s done at clock %0d", req, k), int'(done), (k == lat) ? 1 : 0);
            if (k == lat) begin
                chk("R5", {req, " cycles"}, int'(cycles), e_cyc);
                chk(req, "acc", int'(acc), e_ac);
                chk(req, "link", int'(link), e_l);
                chk(req, "pc", int'(pc), e_pc);
                if (wr != 0) chk(req, "memory word", int'(mem[ea]), wv);
                else         chk(req, "memory untouched", int'(mem[ea]), m);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset acc", int'(acc), 0);
        chk("R1", "reset link", int'(link), 0);
        chk("R1", "reset pc", int'(pc), 0);
        chk("R1", "reset done", int'(done), 0);

        // R3, R7: direct jumps
        poke('o100, 'o010100); run("R7", 'o100, 'o12345, 1);
        poke('o100, 'o010110); run("R7", 'o100, 'o12345, 1);
        // R4, R7: indirect jump
        poke('o100, 'o110110); poke('o110, 'o120); run("R4", 'o100, 'o12345, 1);
        // R8: store direct and indirect
        poke('o100, 'o020101); poke('o101, 0); run("R8", 'o100, 1, 1);
        poke('o100, 'o120101); poke('o101, 'o102); poke('o102, 0); run("R8", 'o100, 'o177777, 1);
        // R9: exchange direct and indirect
        poke('o100, 'o024101); poke('o101, 'o555); run("R9", 'o100, 2, 1);
        poke('o100, 'o124101); poke('o101, 'o102); poke('o102, 'o7); run("R9", 'o100, 'o177777, 0);
        // R11: increment without and with wrap, indirect
        poke('o100, 'o030101); poke('o101, 0); run("R11", 'o100, 2, 1);
        poke('o100, 'o030101); poke('o101, 'o177777); run("R11", 'o100, 2, 1);
        poke('o100, 'o130101); poke('o101, 'o102); poke('o102, 'o177777); run("R11", 'o100, 5, 0);
        // R10: add variants
        poke('o100, 'o064101); poke('o101, 0); run("R10", 'o100, 0, 1);
        poke('o100, 'o064101); poke('o101, 1); run("R10", 'o100, 0, 1);
        poke('o100, 'o064101); poke('o101, 1); run("R10", 'o100, 'o177777, 1);
        poke('o100, 'o064101); poke('o101, 'o100000); run("R10", 'o100, 'o100000, 0);
        poke('o100, 'o164101); poke('o101, 'o103); poke('o103, 'o2); run("R10", 'o100, 'o177777, 0);
        // R12: unknown opcodes, direct and with flag
        poke('o100, 'o070101); run("R12", 'o100, 'o4321, 1);
        poke('o100, 'o170101); run("R12", 'o100, 'o4321, 0);
        // R13: program counter wrap on a store at the top address
        poke(AMASK, 'o020050); run("R13", AMASK, 'o77, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule